// File: doc/BRIEF.md
# Floating-Point Exception Status and Mask Unit

This block keeps the 16-bit status word and the 16-bit control word of a floating-point coprocessor. When an arithmetic operation finishes, the execution datapath reports it as one cycle of exception pulses. Six exception kinds are reported: invalid operation, denormalized operand, divide by zero, overflow, underflow and inexact result (precision). The block records each reported exception in a sticky flag. It compares the pending flags with the per-exception mask bits of the control word and raises an interrupt request while any unmasked flag is pending.

The status word also carries the condition codes and the stack-pointer field supplied by the datapath, a busy bit and an error-summary bit. A store instruction reads it as one 16-bit value. A load-control-word instruction writes the masks, precision mode and rounding mode. The precision and rounding modes are only stored here and are sent out to the arithmetic units. A clear-exceptions command empties all flags.

Top module: `fpu_exc_status`

## Requirements
- R1: After synchronous reset, `status_out` is 16'h0000, `cw_out` is 16'h033F (all six masks 1, precision mode 2'b11, rounding mode 2'b00) and `int_req` is 0.
- R2: On a clock edge with `exc_valid` high, each set bit of `exc_flags` sets the matching status bit (bit 0 invalid, 1 denormal, 2 divide by zero, 3 overflow, 4 underflow, 5 precision), whatever the mask. While `exc_valid` is low, `exc_flags` has no effect.
- R3: Flags are sticky. A flag stays set until an edge with `clr_exc` high clears all six. If `exc_valid` is high on that same edge, the newly reported flags are set after the clear.
- R4: `int_req` is high exactly when some status bit i in 0..5 is 1 and control mask bit i is 0. It changes in the cycle after the flag or mask register changes.
- R5: Status bit 7 (error summary) is the OR of status bits 0..5.
- R6: Status bit 6 (stack fault) always reads 0.
- R7: An edge with `cw_we` high loads the masks from `cw_in[5:0]`, the precision mode from `cw_in[9:8]` and the rounding mode from `cw_in[11:10]`. All other `cw_out` bits read 0. `int_req` is re-evaluated against the already pending flags from the next cycle.
- R8: An edge with `cc_we` high loads C0..C3 from `cc_in[0..3]` into status bits 8, 9, 10 and 14. An edge with `top_we` high loads `top_in` into status bits 13:11. Without the enables, these fields hold their values.
- R9: Status bit 15 shows `busy_in` as registered on the previous edge.
- R10: `pc_mode` and `rc_mode` always equal `cw_out[9:8]` and `cw_out[11:10]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception report strobe from the datapath |
| exc_flags | input | 6 | Exception pulses, one bit per kind |
| clr_exc | input | 1 | Clear-exceptions command |
| cw_we | input | 1 | Control word load strobe |
| cw_in | input | 16 | New control word |
| cc_we | input | 1 | Condition code load strobe |
| cc_in | input | 4 | Condition codes, bit n is Cn |
| top_we | input | 1 | Stack pointer load strobe |
| top_in | input | 3 | Stack pointer value |
| busy_in | input | 1 | Busy indication from the datapath |
| status_out | output | 16 | Assembled status word |
| cw_out | output | 16 | Control word readback |
| pc_mode | output | 2 | Precision mode to the arithmetic units |
| rc_mode | output | 2 | Rounding mode to the arithmetic units |
| int_req | output | 1 | Interrupt request |

## Verification
A flag register that drops its value appears as a cleared status bit and a lost interrupt one cycle after the edge that should have kept it. A corrupted mask register appears on `cw_out`. It also appears as a wrong `int_req` in the cycle after the control word load. A summary or stack-fault bit that does not follow the flags is visible on `status_out` in the same cycle as the flag change. The checks therefore sample every port one cycle after each stimulus edge.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int SW_W  = 16;
    localparam int N_EXC = 6;
    localparam int CC_W  = 4;
    localparam int TOP_W = 3;
    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] PC_RESET = 2'b11;
    localparam logic [MODE_W-1:0] RC_RESET = 2'b00;

    typedef enum int {
        EX_INVALID  = 0,
        EX_DENORMAL = 1,
        EX_ZDIV     = 2,
        EX_OVERFLOW = 3,
        EX_UNDERFLOW= 4,
        EX_PRECISION= 5
    } exc_kind_e;

    typedef struct packed {
        logic [MODE_W-1:0] rc;
        logic [MODE_W-1:0] pc;
        logic [N_EXC-1:0]  mask;
    } ctrl_t;

    typedef struct packed {
        logic              busy;
        logic [CC_W-1:0]   cc;
        logic [TOP_W-1:0]  top;
    } fields_t;

    function automatic logic [SW_W-1:0] pack_status(
        input logic [N_EXC-1:0] flags,
        input fields_t          f
    );
        logic [SW_W-1:0] w;
        w          = '0;
        w[5:0]     = flags;
        w[6]       = 1'b0;
        w[7]       = |flags;
        w[8]       = f.cc[0];
        w[9]       = f.cc[1];
        w[10]      = f.cc[2];
        w[13:11]   = f.top;
        w[14]      = f.cc[3];
        w[15]      = f.busy;
        return w;
    endfunction

    function automatic logic [SW_W-1:0] pack_ctrl(input ctrl_t c);
        logic [SW_W-1:0] w;
        w        = '0;
        w[5:0]   = c.mask;
        w[9:8]   = c.pc;
        w[11:10] = c.rc;
        return w;
    endfunction
endpackage

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
    import fpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SW_W-1:0] wdata,
    output ctrl_t           ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mask <= '1;
            ctrl_q.pc   <= PC_RESET;
            ctrl_q.rc   <= RC_RESET;
        end else if (we) begin
            ctrl_q.mask <= wdata[N_EXC-1:0];
            ctrl_q.pc   <= wdata[9:8];
            ctrl_q.rc   <= wdata[11:10];
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/fpx_exc_flags.sv
module fpx_exc_flags
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rpt_valid,
    input  logic [N_EXC-1:0] rpt_bits,
    input  logic             clear,
    input  logic [N_EXC-1:0] mask,
    output logic [N_EXC-1:0] flags,
    output logic             irq
);
    logic [N_EXC-1:0] pend;
    logic [N_EXC-1:0] live;

    for (genvar i = 0; i < N_EXC; i++) begin : g_flag
        logic hit;
        assign hit = rpt_valid & rpt_bits[i];
        always_ff @(posedge clk) begin
            if (rst)        pend[i] <= 1'b0;
            else if (hit)   pend[i] <= 1'b1;
            else if (clear) pend[i] <= 1'b0;
        end
        assign live[i] = pend[i] & ~mask[i];
    end

    assign flags = pend;
    assign irq   = |live;
endmodule

// File: rtl/fpx_status_fields.sv
module fpx_status_fields
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cc_we,
    input  logic [CC_W-1:0]  cc_in,
    input  logic             top_we,
    input  logic [TOP_W-1:0] top_in,
    input  logic             busy_in,
    output fields_t          fields
);
    fields_t f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q.busy <= busy_in;
            if (cc_we)  f_q.cc  <= cc_in;
            if (top_we) f_q.top <= top_in;
        end
    end

    assign fields = f_q;
endmodule

// File: rtl/fpu_exc_status.sv
module fpu_exc_status
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               exc_valid,
    input  logic [N_EXC-1:0]   exc_flags,
    input  logic               clr_exc,
    input  logic               cw_we,
    input  logic [SW_W-1:0]    cw_in,
    input  logic               cc_we,
    input  logic [CC_W-1:0]    cc_in,
    input  logic               top_we,
    input  logic [TOP_W-1:0]   top_in,
    input  logic               busy_in,
    output logic [SW_W-1:0]    status_out,
    output logic [SW_W-1:0]    cw_out,
    output logic [MODE_W-1:0]  pc_mode,
    output logic [MODE_W-1:0]  rc_mode,
    output logic               int_req
);
    ctrl_t            ctrl;
    fields_t          fields;
    logic [N_EXC-1:0] flags;

    fpx_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (cw_we),
        .wdata (cw_in),
        .ctrl  (ctrl)
    );

    fpx_exc_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .rpt_valid (exc_valid),
        .rpt_bits  (exc_flags),
        .clear     (clr_exc),
        .mask      (ctrl.mask),
        .flags     (flags),
        .irq       (int_req)
    );

    fpx_status_fields u_fields (
        .clk     (clk),
        .rst     (rst),
        .cc_we   (cc_we),
        .cc_in   (cc_in),
        .top_we  (top_we),
        .top_in  (top_in),
        .busy_in (busy_in),
        .fields  (fields)
    );

    assign status_out = pack_status(flags, fields);
    assign cw_out     = pack_ctrl(ctrl);
    assign pc_mode    = ctrl.pc;
    assign rc_mode    = ctrl.rc;
endmodule

// File: rtl/fpx_exc_chk.sv
module fpx_exc_chk
    import fpx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               exc_valid,
    input logic [N_EXC-1:0]   exc_flags,
    input logic               clr_exc,
    input logic               busy_in,
    input logic [SW_W-1:0]    status_out,
    input logic [SW_W-1:0]    cw_out,
    input logic               int_req
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (status_out[7:0] == 8'h00 && cw_out[5:0] == 6'h3F && !int_req));

    // R2
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> ((status_out[5:0] & $past(exc_flags)) == $past(exc_flags)));

    // R3
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_exc |=> ((status_out[5:0] & $past(status_out[5:0])) == $past(status_out[5:0])));

    // R3
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_exc && !exc_valid) |=> (status_out[5:0] == '0));

    // R4
    a_r4_irq_gate: assert property (@(posedge clk) disable iff (rst)
        int_req == |(status_out[5:0] & ~cw_out[5:0]));

    // R5
    a_r5_summary: assert property (@(posedge clk) disable iff (rst)
        status_out[7] == |status_out[5:0]);

    // R6
    a_r6_sf_zero: assert property (@(posedge clk) disable iff (rst)
        !status_out[6]);

    // R9
    a_r9_busy: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (status_out[15] == $past(busy_in)));
endmodule

bind fpu_exc_status fpx_exc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .exc_valid  (exc_valid),
    .exc_flags  (exc_flags),
    .clr_exc    (clr_exc),
    .busy_in    (busy_in),
    .status_out (status_out),
    .cw_out     (cw_out),
    .int_req    (int_req)
);

// File: tb/sim_fpu_exc_status.sv
module sim_fpu_exc_status;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_valid;
    logic [5:0]  exc_flags;
    logic        clr_exc;
    logic        cw_we;
    logic [15:0] cw_in;
    logic        cc_we;
    logic [3:0]  cc_in;
    logic        top_we;
    logic [2:0]  top_in;
    logic        busy_in;
    logic [15:0] status_out;
    logic [15:0] cw_out;
    logic [1:0]  pc_mode;
    logic [1:0]  rc_mode;
    logic        int_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fpu_exc_status u0 (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_flags(exc_flags),
        .clr_exc(clr_exc), .cw_we(cw_we), .cw_in(cw_in), .cc_we(cc_we),
        .cc_in(cc_in), .top_we(top_we), .top_in(top_in), .busy_in(busy_in),
        .status_out(status_out), .cw_out(cw_out), .pc_mode(pc_mode),
        .rc_mode(rc_mode), .int_req(int_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        exc_valid = 0; exc_flags = '0; clr_exc = 0; cw_we = 0; cw_in = '0;
        cc_we = 0; cc_in = '0; top_we = 0; top_in = '0;
    endtask

    // one edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic report(input logic [5:0] f);
        exc_valid = 1; exc_flags = f; step();
    endtask

    task automatic load_cw(input logic [15:0] w);
        cw_we = 1; cw_in = w; step();
    endtask

    task automatic clear();
        clr_exc = 1; step();
    endtask

    task automatic t_reset();
        rst = 1; busy_in = 0; idle_inputs();
        step(); step();
        rst = 0;
        chk("R1 status", status_out, 16'h0000);
        chk("R1 cw", cw_out, 16'h033F);
        chk("R1 irq", {15'd0, int_req}, 16'd0);
    endtask

    task automatic t_masked_capture();
        report(6'b000001);
        chk("R2 invalid flag", {8'd0, status_out[7:0]}, 16'h0081);
        chk("R4 masked no irq", {15'd0, int_req}, 16'd0);
        exc_valid = 0; exc_flags = 6'b111110; step();
        chk("R2 ignored when strobe low", {8'd0, status_out[7:0]}, 16'h0081);
    endtask

    task automatic t_unmask_pending();
        load_cw(16'hFC3E);
        chk("R7 cw readback", cw_out, 16'h0C3E);
        chk("R10 pc", {14'd0, pc_mode}, 16'd0);
        chk("R10 rc", {14'd0, rc_mode}, 16'd3);
        chk("R7 irq re-evaluated", {15'd0, int_req}, 16'd1);
        step(); step();
        chk("R3 sticky", {8'd0, status_out[7:0]}, 16'h0081);
        chk("R4 irq held", {15'd0, int_req}, 16'd1);
        load_cw(16'h003F);
        chk("R7 remask drops irq", {15'd0, int_req}, 16'd0);
        load_cw(16'h003E);
    endtask

    task automatic t_clear();
        clear();
        chk("R3 clear", {8'd0, status_out[7:0]}, 16'h0000);
        chk("R5 summary off", {15'd0, status_out[7]}, 16'd0);
        chk("R4 irq off", {15'd0, int_req}, 16'd0);
        clr_exc = 1; exc_valid = 1; exc_flags = 6'b100000; step();
        chk("R3 set beats clear", {8'd0, status_out[7:0]}, 16'h00A0);
        clear();
    endtask

    task automatic t_each_kind();
        for (int i = 0; i < 6; i++) begin
            logic [5:0] one;
            logic [5:0] other;
            one = 6'(1 << i);
            other = 6'(1 << ((i + 1) % 6));
            load_cw({10'd0, ~one});
            report(other);
            chk("R4 other kind masked", {15'd0, int_req}, 16'd0);
            chk("R6 sf zero", {15'd0, status_out[6]}, 16'd0);
            report(one);
            chk("R2 kind flag", {10'd0, status_out[5:0]}, {10'd0, one | other});
            chk("R4 unmasked irq", {15'd0, int_req}, 16'd1);
            chk("R5 summary on", {15'd0, status_out[7]}, 16'd1);
            clear();
        end
    endtask

    task automatic t_fields();
        cc_we = 1; cc_in = 4'b1010; top_we = 1; top_in = 3'b101; busy_in = 1; step();
        chk("R8 R9 fields", status_out, 16'hEA00);
        cc_in = 4'b0101; top_in = 3'b010; busy_in = 0; step();
        chk("R8 hold, R9 busy drop", status_out, 16'h6A00);
        cc_we = 1; cc_in = 4'b0101; step();
        chk("R8 cc reload", status_out, 16'h2D00);
    endtask

    initial begin
        t_reset();
        t_masked_capture();
        t_unmask_pending();
        t_clear();
        t_each_kind();
        t_fields();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule